// File: doc/BRIEF.md
# Boot Global Chip-Select Unit

This unit drives the select line for the memory that holds the boot image. From a system reset it acts as a global select. It asserts for every bus cycle, at any address, so the processor can fetch its start-up vectors before any address map exists. The first four bus cycles after reset are those fetches: two for a 32-bit stack pointer and two for a 32-bit program counter. Each access runs for a set number of wait states and then gets a transfer acknowledge. The unit also reports the width of the boot port. It takes that width from two data lines while reset is held.

Software then writes a block mask and a wait count into an option register. After that it writes a base address with its valid bit set. From that write on, the unit decodes only the programmed block. Addresses outside the block get no select and no acknowledge. Global decoding is latched off at that point and only a system reset brings it back. Clearing the valid bit later does not bring it back: it leaves the unit selecting nothing.

Top module: `bootsel_unit`

## Requirements
- R1: After reset, and until a valid base is written, `sel_n` is 0 during every strobed bus cycle at any address, including the four boot fetch cycles that follow reset release. `sel_n` is 1 whenever `bus_strobe` is 0.
- R2: The wait count resets to 6. An access under the select gets `xfer_ack` high for exactly one cycle, in the seventh cycle of the strobe (after six wait cycles). It gets no second acknowledge while the strobe stays high.
- R3: `port_size` is sampled from `boot_dhi` (data bits 31:30) on every clock while `rst` is high. The encoding is 00→0 (32-bit), 01→1 (16-bit), 10→2 (8-bit) and 11→0 (32-bit). Changes on `boot_dhi` after reset have no effect on it.
- R4: A write with `cfg_sel`=0 loads the base register. Bits [ADDR_W-1:BLK_LSB] hold the base and bit 0 holds the valid bit. A write with `cfg_sel`=1 loads the option register. Bits [ADDR_W-1:BLK_LSB] hold the block mask and bits [3:0] hold the wait count. Writing the base with valid=0 leaves global decoding on.
- R5: With valid set, the select asserts only when address bits [ADDR_W-1:BLK_LSB] equal the base in every bit position where the mask is 0. Mask bits that are 1, and address bits below BLK_LSB, do not take part in the compare.
- R6: Once valid has been set, global decoding never returns until a system reset. Clearing valid leaves the select off for every address, and setting valid again restores only range decoding.
- R7: An out-of-range access in normal decode gets neither a select nor an acknowledge. `xfer_ack` is only ever high while `sel_n` is 0.
- R8: The wait count can be set from 0 to 15 and applies in both global and range decoding. With 0 the acknowledge comes in the first cycle of the strobe, and with 15 it comes in the sixteenth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| bus_strobe | input | 1 | High for the whole of a bus cycle |
| bus_addr | input | ADDR_W | Bus cycle address |
| boot_dhi | input | 2 | Data bits 31:30, sampled during reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 base, 1 option |
| cfg_wdata | input | ADDR_W | Register write data |
| sel_n | output | 1 | Active-low boot chip select |
| xfer_ack | output | 1 | Transfer acknowledge, one cycle per access |
| port_size | output | 2 | Boot port width code |

## Verification
The bench builds the unit with ADDR_W=16 and BLK_LSB=8, which leaves an 8-bit block tag. With a tag that short, a single table of addresses can cover hits at both edges of a masked block, misses just outside it and misses in far-off high bits. The reset wait count stays at its default of 6. This keeps the exact cycle of the boot-fetch acknowledge in view, and the bench also reprograms the wait count to its limits of 0 and 15. Repeated system resets with each of the four data-line patterns cover both the port-size codes and the return of global decoding.

// File: rtl/bootsel_pkg.sv
package bootsel_pkg;

    localparam int WAIT_W = 4;

    typedef enum logic [1:0] {
        PSZ_32 = 2'b00,
        PSZ_16 = 2'b01,
        PSZ_8  = 2'b10
    } psz_e;

    typedef enum logic {
        REG_BASE = 1'b0,
        REG_OPT  = 1'b1
    } cfg_reg_e;

    function automatic psz_e decode_psz(input logic [1:0] d);
        case (d)
            2'b01:   return PSZ_16;
            2'b10:   return PSZ_8;
            default: return PSZ_32;
        endcase
    endfunction

    function automatic logic tag_hit(input logic [31:0] tag,
                                     input logic [31:0] base,
                                     input logic [31:0] mask);
        return (((tag ^ base) & ~mask) == 32'd0);
    endfunction

endpackage

// File: rtl/bootsel_cfg.sv
module bootsel_cfg
    import bootsel_pkg::*;
#(
    parameter int ADDR_W      = 24,
    parameter int BLK_LSB     = 8,
    parameter int RESET_WAITS = 6,
    localparam int TAG_W      = ADDR_W - BLK_LSB
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic [1:0]        boot_dhi,
    output logic [TAG_W-1:0]  base_q,
    output logic [TAG_W-1:0]  mask_q,
    output logic [WAIT_W-1:0] waits_q,
    output logic              valid_q,
    output logic              glob_q,
    output psz_e              psz_q
);

    logic unused_wbits;
    assign unused_wbits = ^cfg_wdata[BLK_LSB-1:WAIT_W];

    // Base and option registers, plus the one-way global-mode latch
    always_ff @(posedge clk) begin
        if (rst) begin
            base_q  <= '0;
            mask_q  <= '0;
            waits_q <= WAIT_W'(RESET_WAITS);
            valid_q <= 1'b0;
            glob_q  <= 1'b1;
        end else if (cfg_we) begin
            if (cfg_reg_e'(cfg_sel) == REG_BASE) begin
                base_q  <= cfg_wdata[ADDR_W-1:BLK_LSB];
                valid_q <= cfg_wdata[0];
                if (cfg_wdata[0]) begin
                    glob_q <= 1'b0;
                end
            end else begin
                mask_q  <= cfg_wdata[ADDR_W-1:BLK_LSB];
                waits_q <= cfg_wdata[WAIT_W-1:0];
            end
        end
    end

    // Port width follows the data lines only while reset is held
    always_ff @(posedge clk) begin
        if (rst) begin
            psz_q <= decode_psz(boot_dhi);
        end
    end

    // R6: global decoding cannot come back without a reset
    p_global_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        !glob_q |=> !glob_q);

    // R3: port width frozen once reset has been released
    p_psz_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(psz_q));

    // R2: wait count comes out of reset at its default
    p_wait_default_r2: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> waits_q == WAIT_W'(RESET_WAITS));

endmodule

// File: rtl/bootsel_match.sv
module bootsel_match
    import bootsel_pkg::*;
#(
    parameter int TAG_W = 16
) (
    input  logic [TAG_W-1:0] addr_tag,
    input  logic [TAG_W-1:0] base_q,
    input  logic [TAG_W-1:0] mask_q,
    input  logic             valid_q,
    input  logic             glob_q,
    output logic             hit
);

    logic range_hit;

    always_comb begin
        range_hit = valid_q && tag_hit(32'(addr_tag), 32'(base_q), 32'(mask_q));
        hit       = glob_q || range_hit;
    end

endmodule

// File: rtl/bootsel_wait.sv
module bootsel_wait
    import bootsel_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic [WAIT_W-1:0] waits_q,
    output logic              ack
);

    logic [WAIT_W-1:0] wcnt_q;
    logic              done_q;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            wcnt_q <= '0;
            done_q <= 1'b0;
        end else if (!done_q) begin
            if (wcnt_q == waits_q) begin
                done_q <= 1'b1;
            end else begin
                wcnt_q <= wcnt_q + 1'b1;
            end
        end
    end

    assign ack = active && !done_q && (wcnt_q == waits_q);

    // R2: a single acknowledge for each access
    p_single_ack_r2: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);

endmodule

// File: rtl/bootsel_unit.sv
module bootsel_unit
    import bootsel_pkg::*;
#(
    parameter int ADDR_W      = 24,
    parameter int BLK_LSB     = 8,
    parameter int RESET_WAITS = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_strobe,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        boot_dhi,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic              sel_n,
    output logic              xfer_ack,
    output logic [1:0]        port_size
);

    localparam int TAG_W = ADDR_W - BLK_LSB;

    logic [TAG_W-1:0]  base_q;
    logic [TAG_W-1:0]  mask_q;
    logic [WAIT_W-1:0] waits_q;
    logic              valid_q;
    logic              glob_q;
    psz_e              psz_q;
    logic              hit;
    logic              active;
    logic              unused_abits;

    assign unused_abits = ^bus_addr[BLK_LSB-1:0];

    bootsel_cfg #(
        .ADDR_W      (ADDR_W),
        .BLK_LSB     (BLK_LSB),
        .RESET_WAITS (RESET_WAITS)
    ) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .boot_dhi  (boot_dhi),
        .base_q    (base_q),
        .mask_q    (mask_q),
        .waits_q   (waits_q),
        .valid_q   (valid_q),
        .glob_q    (glob_q),
        .psz_q     (psz_q)
    );

    bootsel_match #(
        .TAG_W (TAG_W)
    ) u_match (
        .addr_tag (bus_addr[ADDR_W-1:BLK_LSB]),
        .base_q   (base_q),
        .mask_q   (mask_q),
        .valid_q  (valid_q),
        .glob_q   (glob_q),
        .hit      (hit)
    );

    assign active = bus_strobe && hit;

    bootsel_wait u_wait (
        .clk     (clk),
        .rst     (rst),
        .active  (active),
        .waits_q (waits_q),
        .ack     (xfer_ack)
    );

    assign sel_n     = !active;
    assign port_size = psz_q;

    // R7: acknowledge only under an asserted select
    p_ack_in_sel_r7: assert property (@(posedge clk) disable iff (rst)
        xfer_ack |-> !sel_n);

    // R6: with valid cleared after leaving global mode, nothing is selected
    p_dead_when_invalid_r6: assert property (@(posedge clk) disable iff (rst)
        (!glob_q && !valid_q) |-> sel_n);

    // R1: idle bus never sees a select
    p_idle_no_sel_r1: assert property (@(posedge clk) disable iff (rst)
        !bus_strobe |-> sel_n);

endmodule

// File: tb/test_bootsel_unit.sv
module test_bootsel_unit;

    localparam int ADDR_W  = 16;
    localparam int BLK_LSB = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_strobe = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [1:0]        boot_dhi = 2'b00;
    logic              cfg_we = 1'b0;
    logic              cfg_sel = 1'b0;
    logic [ADDR_W-1:0] cfg_wdata = '0;
    logic              sel_n;
    logic              xfer_ack;
    logic [1:0]        port_size;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    bootsel_unit #(
        .ADDR_W  (ADDR_W),
        .BLK_LSB (BLK_LSB)
    ) i_bootsel_unit (
        .clk        (clk),
        .rst        (rst),
        .bus_strobe (bus_strobe),
        .bus_addr   (bus_addr),
        .boot_dhi   (boot_dhi),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .sel_n      (sel_n),
        .xfer_ack   (xfer_ack),
        .port_size  (port_size)
    );

    // Range table for base tag 0x34, mask 0x03: {address, expected hit}
    localparam logic [16:0] VEC [10] = '{
        {16'h3400, 1'b1}, {16'h34FF, 1'b1}, {16'h3512, 1'b1},
        {16'h3600, 1'b1}, {16'h37FF, 1'b1}, {16'h3800, 1'b0},
        {16'h33FF, 1'b0}, {16'h0000, 1'b0}, {16'hB400, 1'b0},
        {16'h3C00, 1'b0}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] d, input string req);
        int exp_psz;
        exp_psz = (d == 2'b11) ? 0 : int'(d);
        @(negedge clk);
        rst = 1'b1; boot_dhi = d; bus_strobe = 1'b0; cfg_we = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(port_size == 2'(exp_psz), req, "port_size after reset", port_size, exp_psz);
        chk(sel_n == 1'b1, "R1", "sel_n idle after reset", sel_n, 1);
        chk(xfer_ack == 1'b0, "R1", "xfer_ack idle after reset", xfer_ack, 0);
        boot_dhi = ~d;
        @(negedge clk); #1;
        chk(port_size == 2'(exp_psz), "R3", "port_size after data lines change",
            port_size, exp_psz);
    endtask

    task automatic cfg_write(input logic s, input logic [ADDR_W-1:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // One bus cycle; strobe held one cycle past the expected acknowledge
    task automatic access(input logic [ADDR_W-1:0] a, input bit exp_hit,
                          input int waits, input string req);
        @(negedge clk);
        bus_strobe = 1'b1; bus_addr = a;
        for (int i = 0; i <= waits + 1; i++) begin
            #1;
            chk(sel_n == !exp_hit, req, $sformatf("sel_n addr=%h cyc=%0d", a, i),
                sel_n, int'(!exp_hit));
            chk(xfer_ack == (exp_hit && i == waits), req,
                $sformatf("xfer_ack addr=%h cyc=%0d", a, i),
                xfer_ack, int'(exp_hit && i == waits));
            @(negedge clk);
        end
        bus_strobe = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run hung actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R3 reset state, 8-bit code
        do_reset(2'b10, "R3");

        // R1 R2 four boot fetches under global select, six waits
        for (int k = 0; k < 4; k++) access(16'(2 * k), 1'b1, 6, "R2");
        access(16'hFFFE, 1'b1, 6, "R1");

        // R4 R8 option write: mask 0x03, wait 2; still global
        cfg_write(1'b1, 16'h0302);
        access(16'h9000, 1'b1, 2, "R8");
        // R4 base written with valid clear keeps global decode
        cfg_write(1'b0, 16'h3400);
        access(16'h9000, 1'b1, 2, "R4");
        // Set valid: range decode
        cfg_write(1'b0, 16'h3401);

        // R5 R7 range table
        for (int v = 0; v < 10; v++) begin
            access(VEC[v][16:1], VEC[v][0], 2, VEC[v][0] ? "R5" : "R7");
        end

        // R8 limits
        cfg_write(1'b1, 16'h0300);
        access(16'h3500, 1'b1, 0, "R8");
        cfg_write(1'b1, 16'h030F);
        access(16'h3700, 1'b1, 15, "R8");
        cfg_write(1'b1, 16'h0303);

        // R6 clearing valid gives no select anywhere
        cfg_write(1'b0, 16'h3400);
        access(16'h3400, 1'b0, 3, "R6");
        access(16'h9000, 1'b0, 3, "R6");
        // R6 setting valid again: range only, no global
        cfg_write(1'b0, 16'h3401);
        access(16'h3400, 1'b1, 3, "R6");
        access(16'h9000, 1'b0, 3, "R6");

        // R3 R6 each data-line code; reset restores global and six waits
        for (int d = 0; d < 4; d++) begin
            do_reset(2'(d), "R3");
            access(16'h9000, 1'b1, 6, "R6");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule